// File: doc/BRIEF.md
# SD Command Response Receiver

This block listens on the serial command line of an SD/MMC card after the host has sent a command. A start strobe, together with a two-bit response-type code, arms the receiver. It then waits for the card's start bit, shifts in a 48-bit or 136-bit response, and checks its CRC7 where the type asks for one. If the card stays silent for longer than a programmable number of card-clock cycles, the receiver gives up.

When a response is complete, its bits are placed in a small word FIFO that software drains with 16-bit reads. A short response yields three words and a long response yields eight. Three sticky status flags report the outcome: end of response, response timeout and response CRC error. Software clears a flag by writing a one to its bit. Every clock cycle of the block is one card-clock bit time, and the command line is sampled once per cycle.

Top module: `sd_cmd_rsp_rx`

## Requirements
- R1: After reset, `stat` is zero, `fifo_level` is zero, `fifo_dout` is zero and `busy` is low.
- R2: The value of `rsp_type` sampled with `start` selects the response kind: 0 means none, 1 means 48-bit with CRC check, 2 means 136-bit with CRC check, 3 means 48-bit without CRC check. With type 0, the end flag (`stat` bit 13) is set at the `start` edge and no capture takes place.
- R3: With a nonzero type, the first 0 sampled on `cmd_in` after `start` is taken as the start bit. If `cmd_in` is sampled high on as many consecutive cycles as the timeout limit, `busy` drops and the timeout flag (bit 1) and the end flag (bit 13) are set on that same edge.
- R4: The timeout limit resets to 255 cycles and is replaced by `to_wdata` on a cycle where `to_wr` is high.
- R5: A 48-bit response is loaded as three words, with the first-received bit as the most significant bit of word 0. The 32-bit argument therefore occupies the low byte of word 0, all of word 1 and the high byte of word 2.
- R6: A 136-bit response is loaded as eight words holding bits 127..0 of the frame, most significant word first. The start bit, the direction bit and the six reserved bits are dropped.
- R7: For type 1, a CRC7 (x^7+x^3+1, zero initial value) is computed over the first 40 bits of the frame. The CRC error flag (bit 5) is set when that CRC differs from the seven bits that follow.
- R8: For type 3, the CRC error flag is never set, whatever the CRC field holds.
- R9: For type 2, the CRC7 covers frame bits 127..8 and is compared with bits 7..1. A mismatch sets bit 5.
- R10: The end flag is set on the edge that samples the final (end) bit, and all of the response's FIFO words are readable from that same edge on.
- R11: A write with `stat_wr` clears each flag whose bit is 1 in `stat_wdata` and leaves the other flags unchanged. When a flag is set and cleared on the same edge, the set wins.
- R12: A `fifo_rd` pulse removes the head word and `fifo_dout` then shows the next one. A read while the FIFO is empty returns zero and changes nothing.
- R13: A `start` arriving while a capture or wait is in progress abandons it, empties the FIFO and begins a new response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command finished; arm the receiver for one response |
| rsp_type | input | 2 | Response kind, sampled with `start` |
| cmd_in | input | 1 | Serial command line from the card |
| to_wr | input | 1 | Load a new timeout limit |
| to_wdata | input | 8 | Timeout limit in card-clock cycles |
| stat_wr | input | 1 | Write-one-to-clear strobe for the flags |
| stat_wdata | input | 16 | Flags to clear (bit 13 end, bit 5 CRC, bit 1 timeout) |
| stat | output | 16 | Sticky status flags |
| fifo_rd | input | 1 | Pop the head word of the response FIFO |
| fifo_dout | output | 16 | Head word of the response FIFO, zero when empty |
| fifo_level | output | 4 | Number of words held in the FIFO |
| busy | output | 1 | Waiting for or receiving a response |

## Verification
Short frames with a correct CRC under type 1 check the word packing of the argument bytes. The same frames with a flipped CRC bit, run under types 1 and 3, show whether the check is tied to the type rather than to the frame length. Long frames, once with an intact payload and once with a single payload bit corrupted, confirm that the long-frame CRC covers only the inner 120 bits.

Silent lines are run against both the reset limit and a short written limit. Start bits that arrive one cycle inside that limit show whether the boundary is off by one. A restart in mid-frame and a clear held active during the final bit probe restart and set-over-clear. A behavioural model compares every output on every cycle, so each of these patterns is also checked for its exact timing.

// File: rtl/sd_rsp_pkg.sv
package sd_rsp_pkg;

  localparam int WORD_W      = 16;
  localparam int STAT_W      = 16;
  localparam int FRAME_MAX   = 136;
  localparam int SHORT_LEN   = 48;
  localparam int LONG_LEN    = 136;
  localparam int LONG_PAY    = 128;
  localparam int SHORT_CRC_N = 40;
  localparam int LONG_HDR    = 8;
  localparam int FIFO_DEPTH  = LONG_PAY / WORD_W;
  localparam int SHORT_WORDS = SHORT_LEN / WORD_W;
  localparam int LVL_W       = $clog2(FIFO_DEPTH + 1);
  localparam int PACK_W      = FIFO_DEPTH * WORD_W;

  localparam int FLAG_END = 13;
  localparam int FLAG_CRC = 5;
  localparam int FLAG_TO  = 1;
  localparam logic [STAT_W-1:0] FLAG_MASK =
    STAT_W'((1 << FLAG_END) | (1 << FLAG_CRC) | (1 << FLAG_TO));

  typedef enum logic [1:0] {
    RSP_NONE      = 2'd0,
    RSP_SHORT_CRC = 2'd1,
    RSP_LONG      = 2'd2,
    RSP_SHORT_RAW = 2'd3
  } rsp_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_CAP  = 2'd2
  } rx_state_e;

  // One serial step of the x^7 + x^3 + 1 remainder register.
  function automatic logic [6:0] crc7_next(input logic [6:0] crc, input logic b);
    logic fb;
    fb = crc[6] ^ b;
    return {crc[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
  endfunction

  // Total frame length in bits, counting start and end bits.
  function automatic logic [7:0] frame_len(input rsp_kind_e k);
    return (k == RSP_LONG) ? 8'(LONG_LEN) : 8'(SHORT_LEN);
  endfunction

  // True when the bit at position idx (0 = start bit) is covered by the CRC.
  function automatic logic crc_covers(input rsp_kind_e k, input logic [7:0] idx);
    if (k == RSP_LONG)
      return (idx >= 8'(LONG_HDR)) && (idx < 8'(LONG_PAY));
    return idx < 8'(SHORT_CRC_N);
  endfunction

  // Word image loaded into the FIFO, word 0 in the top slice.
  function automatic logic [PACK_W-1:0] pack_words(input logic [FRAME_MAX-1:0] fr,
                                                   input logic is_long);
    if (is_long)
      return fr[LONG_PAY-1:0];
    return {fr[SHORT_LEN-1:0], {(PACK_W-SHORT_LEN){1'b0}}};
  endfunction

  function automatic logic [LVL_W-1:0] word_count(input logic is_long);
    return is_long ? LVL_W'(FIFO_DEPTH) : LVL_W'(SHORT_WORDS);
  endfunction

endpackage

// File: rtl/sd_rsp_deser.sv
module sd_rsp_deser
  import sd_rsp_pkg::*;
#(
  parameter int TO_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [1:0]           kind,
  input  logic                 cmd_in,
  input  logic [TO_W-1:0]      to_lim,
  output logic                 busy,
  output logic                 fin_evt,
  output logic                 to_evt,
  output logic                 none_evt,
  output logic                 crc_bad,
  output logic                 cur_long,
  output logic [FRAME_MAX-1:0] frame
);

  localparam logic [TO_W:0] CNT_ONE = (TO_W+1)'(1);

  rx_state_e            state;
  rsp_kind_e            cur_kind;
  logic [TO_W:0]        wait_cnt;
  logic [7:0]           bit_idx;
  logic [FRAME_MAX-2:0] sr;
  logic [6:0]           crc_q;
  logic [7:0]           len;
  logic                 at_last;

  always_comb begin
    len      = frame_len(cur_kind);
    at_last  = (state == ST_CAP) && (bit_idx == len - 8'd1);
    fin_evt  = at_last && !start;
    to_evt   = (state == ST_WAIT) && cmd_in && !start &&
               ((wait_cnt + CNT_ONE) >= {1'b0, to_lim});
    none_evt = start && (rsp_kind_e'(kind) == RSP_NONE);
    frame    = {sr, cmd_in};
    crc_bad  = fin_evt && (cur_kind != RSP_SHORT_RAW) && (crc_q != frame[7:1]);
    busy     = (state != ST_IDLE);
    cur_long = (cur_kind == RSP_LONG);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cur_kind <= RSP_NONE;
      wait_cnt <= '0;
      bit_idx  <= '0;
      sr       <= '0;
      crc_q    <= '0;
    end else if (start) begin
      cur_kind <= rsp_kind_e'(kind);
      wait_cnt <= '0;
      state    <= (rsp_kind_e'(kind) == RSP_NONE) ? ST_IDLE : ST_WAIT;
    end else begin
      unique case (state)
        ST_WAIT: begin
          if (!cmd_in) begin
            state   <= ST_CAP;
            bit_idx <= 8'd1;
            sr      <= '0;
            crc_q   <= '0;
          end else if (to_evt) begin
            state <= ST_IDLE;
          end else begin
            wait_cnt <= wait_cnt + CNT_ONE;
          end
        end
        ST_CAP: begin
          sr      <= {sr[FRAME_MAX-3:0], cmd_in};
          bit_idx <= bit_idx + 8'd1;
          if (crc_covers(cur_kind, bit_idx))
            crc_q <= crc7_next(crc_q, cmd_in);
          if (at_last)
            state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sd_rsp_fifo.sv
module sd_rsp_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       load,
  input  logic [$clog2(DEPTH+1)-1:0] load_cnt,
  input  logic [DEPTH*W-1:0]         load_data,
  input  logic                       rd,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0] level
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int LVL_W = $clog2(DEPTH+1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[i] <= '0;
      else if (load && !clr)
        mem[i] <= load_data[(DEPTH-1-i)*W +: W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      level  <= '0;
    end else if (clr) begin
      rd_ptr <= '0;
      level  <= '0;
    end else if (load) begin
      rd_ptr <= '0;
      level  <= load_cnt;
    end else if (rd && (level != '0)) begin
      rd_ptr <= rd_ptr + PTR_W'(1);
      level  <= level - LVL_W'(1);
    end
  end

  assign dout = (level != '0) ? mem[rd_ptr] : '0;

endmodule

// File: rtl/sd_rsp_status.sv
module sd_rsp_status #(
  parameter int          W    = 16,
  parameter logic [15:0] MASK = 16'h2022
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic         clr_en,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] stat
);

  logic [W-1:0] nxt;

  always_comb begin
    nxt = stat & ~(clr_en ? clr_vec : '0);
    nxt = (nxt | set_vec) & W'(MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      stat <= '0;
    else
      stat <= nxt;
  end

endmodule

// File: rtl/sd_cmd_rsp_rx.sv
module sd_cmd_rsp_rx
  import sd_rsp_pkg::*;
#(
  parameter int          TO_W     = 8,
  parameter logic [7:0]  TO_RESET = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        rsp_type,
  input  logic              cmd_in,
  input  logic              to_wr,
  input  logic [TO_W-1:0]   to_wdata,
  input  logic              stat_wr,
  input  logic [STAT_W-1:0] stat_wdata,
  output logic [STAT_W-1:0] stat,
  input  logic              fifo_rd,
  output logic [WORD_W-1:0] fifo_dout,
  output logic [LVL_W-1:0]  fifo_level,
  output logic              busy
);

  logic [TO_W-1:0]      to_lim;
  logic                 fin_evt;
  logic                 to_evt;
  logic                 none_evt;
  logic                 crc_bad;
  logic                 cur_long;
  logic [FRAME_MAX-1:0] frame;
  logic [STAT_W-1:0]    set_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      to_lim <= TO_W'(TO_RESET);
    else if (to_wr)
      to_lim <= to_wdata;
  end

  sd_rsp_deser #(.TO_W(TO_W)) u_deser (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .kind     (rsp_type),
    .cmd_in   (cmd_in),
    .to_lim   (to_lim),
    .busy     (busy),
    .fin_evt  (fin_evt),
    .to_evt   (to_evt),
    .none_evt (none_evt),
    .crc_bad  (crc_bad),
    .cur_long (cur_long),
    .frame    (frame)
  );

  sd_rsp_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (start),
    .load      (fin_evt),
    .load_cnt  (word_count(cur_long)),
    .load_data (pack_words(frame, cur_long)),
    .rd        (fifo_rd),
    .dout      (fifo_dout),
    .level     (fifo_level)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[FLAG_END] = fin_evt | to_evt | none_evt;
    set_vec[FLAG_TO]  = to_evt;
    set_vec[FLAG_CRC] = crc_bad;
  end

  sd_rsp_status #(.W(STAT_W), .MASK(FLAG_MASK)) u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_en  (stat_wr),
    .clr_vec (stat_wdata),
    .stat    (stat)
  );

endmodule

// File: rtl/sd_rsp_rx_chk.sv
module sd_rsp_rx_chk
  import sd_rsp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              fifo_rd,
  input logic              stat_wr,
  input logic [STAT_W-1:0] stat_wdata,
  input logic [STAT_W-1:0] stat,
  input logic [LVL_W-1:0]  fifo_level,
  input logic              busy,
  input logic              fin_evt,
  input logic [STAT_W-1:0] set_vec
);

  assert_timeout_with_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[FLAG_TO]) |-> stat[FLAG_END]);

  assert_crc_with_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[FLAG_CRC]) |-> stat[FLAG_END]);

  assert_end_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> stat[FLAG_END]);

  assert_load_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fin_evt |=> (fifo_level == LVL_W'(SHORT_WORDS)) || (fifo_level == LVL_W'(FIFO_DEPTH)));

  assert_level_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LVL_W'(FIFO_DEPTH));

  assert_empty_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_rd && fifo_level == '0 && !start && !fin_evt) |=> fifo_level == '0);

  assert_start_clears_R13: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> fifo_level == '0);

  assert_w1c_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && stat_wdata[FLAG_TO] && !set_vec[FLAG_TO]) |=> !stat[FLAG_TO]);

  assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    set_vec[FLAG_END] |=> stat[FLAG_END]);

endmodule

bind sd_cmd_rsp_rx sd_rsp_rx_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .fifo_rd    (fifo_rd),
  .stat_wr    (stat_wr),
  .stat_wdata (stat_wdata),
  .stat       (stat),
  .fifo_level (fifo_level),
  .busy       (busy),
  .fin_evt    (fin_evt),
  .set_vec    (set_vec)
);

// File: tb/sd_cmd_rsp_rx_tb.sv
module sd_cmd_rsp_rx_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  rsp_type = 2'd0;
  logic        cmd_in = 1'b1;
  logic        to_wr = 1'b0;
  logic [7:0]  to_wdata = 8'd0;
  logic        stat_wr = 1'b0;
  logic [15:0] stat_wdata = 16'd0;
  logic        fifo_rd = 1'b0;
  wire  [15:0] stat;
  wire  [15:0] fifo_dout;
  wire  [3:0]  fifo_level;
  wire         busy;

  sd_cmd_rsp_rx u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .rsp_type(rsp_type), .cmd_in(cmd_in),
    .to_wr(to_wr), .to_wdata(to_wdata), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .stat(stat), .fifo_rd(fifo_rd), .fifo_dout(fifo_dout), .fifo_level(fifo_level),
    .busy(busy)
  );

  always #2 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  int cyc = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual 0x%0h expected 0x%0h", req, $time, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // CRC7 as polynomial long division of M(x)*x^7 by x^7+x^3+1
  function automatic logic [6:0] crc_div(input logic [135:0] fr, input int hi, input int lo);
    logic [7:0] r = 8'd0;
    for (int i = hi; i >= lo; i--) begin
      r = {r[6:0], fr[i]};
      if (r[7]) r ^= 8'h89;
    end
    for (int j = 0; j < 7; j++) begin
      r = {r[6:0], 1'b0};
      if (r[7]) r ^= 8'h89;
    end
    return r[6:0];
  endfunction

  function automatic logic [135:0] mk_short(input logic [5:0] idx, input logic [31:0] arg);
    logic [135:0] r = '0;
    r[47:0] = {2'b00, idx, arg, 7'd0, 1'b1};
    r[7:1]  = crc_div(r, 47, 8);
    return r;
  endfunction

  function automatic logic [135:0] mk_long(input logic [119:0] pl);
    logic [135:0] r;
    r = {2'b00, 6'h3F, pl, 7'd0, 1'b1};
    r[7:1] = crc_div(r, 127, 8);
    return r;
  endfunction

  // ---------------- behavioural reference model ----------------
  int          m_mode = 0;
  int          m_cnt = 0;
  int          m_kind = 0;
  int          m_lim = 255;
  logic [15:0] m_stat = 16'd0;
  logic [15:0] fq[$];
  bit          bq[$];

  always @(posedge clk) begin
    logic [15:0]  ev;
    logic [135:0] fr;
    int           len;
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; m_kind = 0; m_lim = 255; m_stat = 16'd0;
      fq.delete(); bq.delete();
    end else begin
      ev = 16'd0;
      if (start) begin
        fq.delete();
        if (rsp_type == 2'd0) begin
          ev[13] = 1'b1;
          m_mode = 0;
        end else begin
          m_mode = 1; m_cnt = 0; m_kind = int'(rsp_type);
        end
      end else begin
        if (fifo_rd && fq.size() > 0) void'(fq.pop_front());
        if (m_mode == 1) begin
          if (!cmd_in) begin
            m_mode = 2; bq.delete(); bq.push_back(1'b0);
          end else begin
            m_cnt++;
            if (m_cnt >= m_lim) begin
              ev[1] = 1'b1; ev[13] = 1'b1; m_mode = 0;
            end
          end
        end else if (m_mode == 2) begin
          bq.push_back(cmd_in);
          len = (m_kind == 2) ? 136 : 48;
          if (bq.size() == len) begin
            fr = '0;
            foreach (bq[i]) fr = {fr[134:0], bq[i]};
            if (len == 48) begin
              fq.push_back(fr[47:32]); fq.push_back(fr[31:16]); fq.push_back(fr[15:0]);
              if (m_kind == 1 && crc_div(fr, 47, 8) != fr[7:1]) ev[5] = 1'b1;
            end else begin
              for (int k = 7; k >= 0; k--) fq.push_back(fr[16*k +: 16]);
              if (crc_div(fr, 127, 8) != fr[7:1]) ev[5] = 1'b1;
            end
            ev[13] = 1'b1;
            m_mode = 0;
          end
        end
      end
      if (stat_wr) m_stat = m_stat & ~stat_wdata;
      m_stat = (m_stat | ev) & 16'h2022;
      if (to_wr) m_lim = int'(to_wdata);
    end
  end

  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk("R10 stat", {16'd0, stat}, {16'd0, m_stat});
      chk("R12 level", {28'd0, fifo_level}, fq.size());
      chk("R12 dout", {16'd0, fifo_dout}, (fq.size() > 0) ? {16'd0, fq[0]} : 32'd0);
      chk("R3 busy", {31'd0, busy}, (m_mode != 0) ? 32'd1 : 32'd0);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      report();
    end
  end

  // ---------------- stimulus ----------------
  task automatic kick(input logic [1:0] k);
    @(negedge clk); start = 1'b1; rsp_type = k; cmd_in = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic issue(input logic [1:0] k, input logic [135:0] fr, input int len,
                       input int nbits, input int gap);
    kick(k);
    repeat (gap) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      cmd_in = fr[len-1-i];
      @(negedge clk);
    end
    cmd_in = 1'b1;
  endtask

  task automatic pop(output logic [15:0] w);
    w = fifo_dout;
    fifo_rd = 1'b1;
    @(negedge clk);
    fifo_rd = 1'b0;
  endtask

  task automatic clr(input logic [15:0] v);
    @(negedge clk); stat_wr = 1'b1; stat_wdata = v;
    @(negedge clk); stat_wr = 1'b0;
  endtask

  task automatic set_lim(input logic [7:0] v);
    @(negedge clk); to_wr = 1'b1; to_wdata = v;
    @(negedge clk); to_wr = 1'b0;
  endtask

  initial begin
    logic [135:0] fa, fb;
    logic [15:0]  w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 stat", {16'd0, stat}, 0);
    chk("R1 level", {28'd0, fifo_level}, 0);
    chk("R1 dout", {16'd0, fifo_dout}, 0);
    chk("R1 busy", {31'd0, busy}, 0);

    // R4: default limit of 255 silent cycles
    kick(2'd1);
    repeat (250) @(negedge clk);
    chk("R4 still waiting", {31'd0, busy}, 1);
    repeat (8) @(negedge clk);
    chk("R4 timed out", {31'd0, busy}, 0);
    chk("R4 flags", {16'd0, stat}, 32'h2002);
    clr(16'hFFFF);

    // R2: no response expected
    kick(2'd0);
    chk("R2 end flag", {31'd0, stat[13]}, 1);
    chk("R2 idle", {31'd0, busy}, 0);
    chk("R2 fifo", {28'd0, fifo_level}, 0);
    clr(16'hFFFF);
    chk("R11 all cleared", {16'd0, stat}, 0);

    // R5 / R7 / R10: short response with good CRC
    fa = mk_short(6'd17, 32'hDEADBEEF);
    issue(2'd1, fa, 48, 48, 3);
    chk("R10 end at last bit", {31'd0, stat[13]}, 1);
    chk("R7 good crc", {31'd0, stat[5]}, 0);
    chk("R5 three words", {28'd0, fifo_level}, 3);
    pop(w); chk("R5 word0", {16'd0, w}, {16'd0, 2'b00, 6'd17, 8'hDE});
    pop(w); chk("R5 word1", {16'd0, w}, 32'h0000ADBE);
    pop(w); chk("R5 word2", {16'd0, w}, {16'd0, 8'hEF, fa[7:0]});
    pop(w); chk("R12 empty read", {16'd0, w}, 0);
    chk("R12 empty level", {28'd0, fifo_level}, 0);
    clr(16'hFFFF);

    // R7: corrupted CRC under type 1
    fb = fa ^ 136'h2;
    issue(2'd1, fb, 48, 48, 0);
    chk("R7 crc error", {31'd0, stat[5]}, 1);
    clr(16'hFFFF);

    // R8: same frame, type 3 ignores CRC
    issue(2'd3, fb, 48, 48, 1);
    chk("R8 no crc flag", {31'd0, stat[5]}, 0);
    chk("R8 end", {31'd0, stat[13]}, 1);
    clr(16'hFFFF);

    // R6 / R9: long response
    fa = mk_long(120'h0123_4567_89AB_CDEF_FEDC_BA98_7654_32);
    issue(2'd2, fa, 136, 136, 0);
    chk("R9 good long crc", {31'd0, stat[5]}, 0);
    chk("R6 eight words", {28'd0, fifo_level}, 8);
    for (int k = 7; k >= 0; k--) begin
      pop(w);
      chk("R6 long word", {16'd0, w}, {16'd0, fa[16*k +: 16]});
    end
    issue(2'd2, fa ^ (136'h1 << 60), 136, 136, 2);
    chk("R9 long crc error", {31'd0, stat[5]}, 1);

    // R11: selective clear
    clr(16'h2000);
    chk("R11 crc kept", {31'd0, stat[5]}, 1);
    chk("R11 end cleared", {31'd0, stat[13]}, 0);
    clr(16'hFFFF);

    // R3: short limit, silent line and late start bit
    set_lim(8'd10);
    kick(2'd1);
    repeat (8) @(negedge clk);
    chk("R3 waiting", {31'd0, busy}, 1);
    repeat (4) @(negedge clk);
    chk("R3 timeout", {16'd0, stat}, 32'h2002);
    clr(16'hFFFF);
    fa = mk_short(6'd2, 32'h0000_0900);
    issue(2'd1, fa, 48, 48, 9);
    chk("R3 late start accepted", {31'd0, stat[1]}, 0);
    chk("R3 late start end", {31'd0, stat[13]}, 1);
    set_lim(8'hFF);
    clr(16'hFFFF);

    // R13: restart in mid-frame
    fa = mk_short(6'd5, 32'h1111_2222);
    fb = mk_short(6'd9, 32'hCAFE_F00D);
    issue(2'd1, fa, 48, 20, 0);
    issue(2'd1, fb, 48, 48, 1);
    pop(w); chk("R13 word0", {16'd0, w}, {16'd0, fb[47:32]});
    pop(w); chk("R13 word1", {16'd0, w}, 32'h0000FEF0);
    pop(w); chk("R13 word2", {16'd0, w}, {16'd0, fb[15:0]});

    // R11: clear held during the final bit, set wins
    @(negedge clk); stat_wr = 1'b1; stat_wdata = 16'hFFFF;
    issue(2'd3, fa, 48, 48, 0);
    chk("R11 set wins", {31'd0, stat[13]}, 1);
    stat_wr = 1'b0;
    clr(16'hFFFF);

    // mixed traffic checked by the model
    for (int n = 0; n < 6; n++) begin
      logic [1:0] k;
      k = 2'(1 + (n % 3));
      if (k == 2'd2) fa = mk_long({$urandom, $urandom, $urandom, 24'($urandom)});
      else           fa = mk_short(6'($urandom), $urandom);
      if (n == 4) fa = fa ^ 136'h8;
      issue(k, fa, (k == 2'd2) ? 136 : 48, (k == 2'd2) ? 136 : 48, n % 4);
      repeat (2) begin pop(w); end
      clr(16'hFFFF);
    end

    repeat (4) @(negedge clk);
    done = 1;
    report();
  end

endmodule